// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a block of data from a source address to a destination address over a memory-mapped master port. Each item is moved by one bus read followed by one bus write, and the write carries the data the read returned. Software programs a small register set with a source pointer, a destination pointer, a byte count and a control word. It then starts the channel, either directly or by handing pacing to a peripheral request line. The source and destination each have their own item size and their own increment enable. The count shrinks by the larger of the two sizes for every item moved.

On completion the channel raises a DONE flag and can raise an interrupt. It can also drop its own peripheral-request enable so that a peripheral does not re-arm it. Software stops a running channel by writing one to DONE. Control-word writes change the channel's behaviour at once, even mid-block. If the programmed setup cannot be moved cleanly, the channel refuses to start and sets a configuration error flag.

Top module: `dma_channel`

## Requirements
- R1: After each item whose write is accepted, SRC advances by the source size in bytes (1, 2 or 4 for size code 0, 1, 2) when the source increment bit is set, and is unchanged otherwise.
- R2: After each item, DST advances by the destination size in bytes when the destination increment bit is set, and is unchanged otherwise.
- R3: After each item, COUNT drops by the larger of the two sizes. When it reaches zero, STAT.DONE (bit 0) is set, STAT.BUSY (bit 1) is cleared and COUNT reads 0.
- R4: While DONE is set, neither a START write nor a peripheral request starts the channel. BUSY stays 0 and no bus access occurs.
- R5: With the request enable (CTRL bit 1) clear, START makes the channel begin bus accesses at once. With it set, each item waits for `periph_req` to be high, and a high `periph_req` also arms an idle channel whose DONE and error flags are clear.
- R6: One write of CTRL (index 3) loads all fields and, if START (bit 0) is set, starts the channel using the newly written fields. START always reads back 0.
- R7: If auto-off (CTRL bit 2) is set when the last item completes, the request enable is cleared. If auto-off is clear, the request enable is kept.
- R8: Writing 1 to STAT bit 0 stops a running channel: from the next cycle `m_valid` is low, BUSY and DONE read 0 and COUNT keeps its remaining value.
- R9: A CTRL write without START takes effect immediately on an active channel. For example, clearing the request enable lets a waiting transfer run without `periph_req`.
- R10: `irq` is high exactly while DONE is set and the interrupt enable (CTRL bit 9) is set.
- R11: Starting with COUNT 0, a size code of 3, an address not aligned to its size, or a COUNT that is not a multiple of the larger size sets STAT.ERR (bit 2) with no bus access. Writing 1 to STAT bit 2 clears it.
- R12: Every item is one read (`m_write`=0) at SRC with the source size, then one write (`m_write`=1) at DST with the destination size, whose `m_wdata` is the `m_rdata` taken when the read was accepted. Each access holds until `m_valid` and `m_ready` are both high.
- R13: Writes to SRC (index 0), DST (index 1) and COUNT (index 2) are ignored while BUSY is set.
- R14: After reset every register reads 0, `m_valid` and `irq` are low, and register indices 5 to 7 read 0. CTRL fields are START 0, request enable 1, auto-off 2, source increment 3, destination increment 4, source size 6:5, destination size 8:7, interrupt enable 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 SRC, 1 DST, 2 COUNT, 3 CTRL, 4 STAT) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| periph_req | input | 1 | Peripheral transfer request |
| m_valid | output | 1 | Bus access request |
| m_write | output | 1 | 1 for write, 0 for read |
| m_addr | output | 32 | Byte address of the access |
| m_size | output | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| m_wdata | output | 32 | Write data, item in the low bytes |
| m_ready | input | 1 | Bus accepts the access this cycle |
| m_rdata | input | 32 | Read data, valid when a read is accepted, item in the low bytes |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume a bus slave that presents `m_rdata` in the cycle it raises `m_ready` for a read, and that sooner or later accepts every access. The bench responder meets this by re-drawing `m_ready` at random every cycle and supplying data from a byte-array memory. The assertions also assume that software loads pointers and counts only while the channel is idle. The randomized blocks honour this: they use aligned pointers in disjoint source and destination halves of the memory, and counts that are whole multiples of the larger size. Directed cases deliberately break the alignment and count rules to reach the error path. They also write pointers during a run to show those writes are ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_IDX_W = 3;
    localparam int CTRL_W    = 10;

    typedef enum logic [2:0] {
        RI_SRC  = 3'd0,
        RI_DST  = 3'd1,
        RI_CNT  = 3'd2,
        RI_CTRL = 3'd3,
        RI_STAT = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xsize_e;

    // bit 0 is START, bit 9 is the interrupt enable
    typedef struct packed {
        logic   irq_en;
        xsize_e dst_size;
        xsize_e src_size;
        logic   dst_inc;
        logic   src_inc;
        logic   auto_off;
        logic   req_en;
        logic   start;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;

    function automatic logic [2:0] size_bytes(xsize_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] step_bytes(xsize_e a, xsize_e b);
        logic [2:0] na;
        logic [2:0] nb;
        na = size_bytes(a);
        nb = size_bytes(b);
        return (na > nb) ? na : nb;
    endfunction

    function automatic logic misaligned(logic [1:0] low, xsize_e s);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return low[0];
            default: return |low;
        endcase
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 periph_req,
    input  logic                 step,
    output logic [ADDR_W-1:0]    src_q,
    output logic [ADDR_W-1:0]    dst_q,
    output ctrl_t                ctrl_q,
    output logic                 busy_q,
    output logic                 irq
);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             err_q;

    logic  wr_src, wr_dst, wr_cnt, wr_ctrl, wr_stat;
    ctrl_t wctrl;
    ctrl_t eff_ctrl;
    logic  sw_start, hw_start, try_start;
    logic  clr_done, clr_err;
    logic  cfg_bad;
    logic  [2:0] step_now;
    logic  [2:0] start_step;
    logic  last;

    assign wr_src  = cfg_we && (cfg_addr == RI_SRC);
    assign wr_dst  = cfg_we && (cfg_addr == RI_DST);
    assign wr_cnt  = cfg_we && (cfg_addr == RI_CNT);
    assign wr_ctrl = cfg_we && (cfg_addr == RI_CTRL);
    assign wr_stat = cfg_we && (cfg_addr == RI_STAT);

    assign wctrl    = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    assign eff_ctrl = wr_ctrl ? wctrl : ctrl_q;

    assign clr_done  = wr_stat && cfg_wdata[0];
    assign clr_err   = wr_stat && cfg_wdata[2];
    assign sw_start  = wr_ctrl && wctrl.start;
    assign hw_start  = ctrl_q.req_en && periph_req && !err_q;
    assign try_start = !busy_q && !done_q && !clr_done && (sw_start || hw_start);

    assign start_step = step_bytes(eff_ctrl.src_size, eff_ctrl.dst_size);
    assign cfg_bad = (cnt_q == '0)
                  || (eff_ctrl.src_size == SZ_BAD)
                  || (eff_ctrl.dst_size == SZ_BAD)
                  || misaligned(src_q[1:0], eff_ctrl.src_size)
                  || misaligned(dst_q[1:0], eff_ctrl.dst_size)
                  || ((cnt_q[1:0] & (start_step[1:0] - 2'd1)) != 2'd0);

    // live sizes: a control write mid-block changes the next step at once
    assign step_now = step_bytes(ctrl_q.src_size, ctrl_q.dst_size);
    assign last     = (cnt_q <= CNT_W'(step_now));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (!busy_q) begin
                if (wr_src) src_q <= cfg_wdata[ADDR_W-1:0];
                if (wr_dst) dst_q <= cfg_wdata[ADDR_W-1:0];
                if (wr_cnt) cnt_q <= cfg_wdata[CNT_W-1:0];
            end else if (step) begin
                if (ctrl_q.src_inc) src_q <= src_q + ADDR_W'(size_bytes(ctrl_q.src_size));
                if (ctrl_q.dst_inc) dst_q <= dst_q + ADDR_W'(size_bytes(ctrl_q.dst_size));
                cnt_q <= last ? '0 : cnt_q - CNT_W'(step_now);
            end

            if (wr_ctrl) begin
                ctrl_q       <= wctrl;
                ctrl_q.start <= 1'b0;
            end else if (step && last && ctrl_q.auto_off) begin
                ctrl_q.req_en <= 1'b0;
            end

            if (clr_err)
                err_q <= 1'b0;
            else if (try_start && cfg_bad)
                err_q <= 1'b1;

            if (clr_done) begin
                done_q <= 1'b0;
                busy_q <= 1'b0;
            end else if (step && last) begin
                done_q <= 1'b1;
                busy_q <= 1'b0;
            end else if (try_start && !cfg_bad) begin
                busy_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (cfg_addr)
            RI_SRC:  cfg_rdata = DATA_W'(src_q);
            RI_DST:  cfg_rdata = DATA_W'(dst_q);
            RI_CNT:  cfg_rdata = DATA_W'(cnt_q);
            RI_CTRL: cfg_rdata = DATA_W'(ctrl_q);
            RI_STAT: cfg_rdata = DATA_W'({err_q, busy_q, done_q});
            default: cfg_rdata = '0;
        endcase
    end

    assign irq = done_q && ctrl_q.irq_en;

    AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q != '0)); // R3

    AST_DONE_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (done_q && !clr_done) |=> !busy_q); // R4

    AST_AUTO_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (step && last && ctrl_q.auto_off && !wr_ctrl) |=> !ctrl_q.req_en); // R7

    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> !busy_q); // R11

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              req_en,
    input  logic              periph_req,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  xsize_e            src_size,
    input  xsize_e            dst_size,
    output logic              m_valid,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ready,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              step
);

    eng_state_e        state_q;
    logic [DATA_W-1:0] data_q;

    // dropping busy (abort) withdraws the request at once
    assign m_valid = busy && (state_q != ST_IDLE);
    assign m_write = (state_q == ST_WRITE);
    assign m_addr  = m_write ? dst_addr : src_addr;
    assign m_size  = m_write ? dst_size : src_size;
    assign m_wdata = data_q;
    assign step    = m_valid && m_write && m_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else if (!busy) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (!req_en || periph_req) state_q <= ST_READ;
                ST_READ: if (m_ready) begin
                    data_q  <= m_rdata;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: if (m_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_WAIT_FOR_REQ: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q == ST_IDLE && req_en && !periph_req) |=> !m_valid); // R5

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_write && m_ready) |=>
            (!busy || (m_valid && m_write && m_wdata == $past(m_rdata)))); // R12

    AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (!m_valid || $stable(m_write))); // R12

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 periph_req,
    output logic                 m_valid,
    output logic                 m_write,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [1:0]           m_size,
    output logic [DATA_W-1:0]    m_wdata,
    input  logic                 m_ready,
    input  logic [DATA_W-1:0]    m_rdata,
    output logic                 irq
);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    ctrl_t             ctrl_q;
    logic              busy_q;
    logic              step;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .periph_req (periph_req),
        .step       (step),
        .src_q      (src_q),
        .dst_q      (dst_q),
        .ctrl_q     (ctrl_q),
        .busy_q     (busy_q),
        .irq        (irq)
    );

    dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy_q),
        .req_en     (ctrl_q.req_en),
        .periph_req (periph_req),
        .src_addr   (src_q),
        .dst_addr   (dst_q),
        .src_size   (ctrl_q.src_size),
        .dst_size   (ctrl_q.dst_size),
        .m_valid    (m_valid),
        .m_write    (m_write),
        .m_addr     (m_addr),
        .m_size     (m_size),
        .m_wdata    (m_wdata),
        .m_ready    (m_ready),
        .m_rdata    (m_rdata),
        .step       (step)
    );

endmodule

// File: tb/test_dma_channel.sv
module test_dma_channel;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        periph_req;
    logic        m_valid, m_write;
    logic [31:0] m_addr;
    logic [1:0]  m_size;
    logic [31:0] m_wdata;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        irq;

    logic [7:0] mem   [0:255];
    logic [7:0] model [0:255];
    int tests = 0;
    int fails = 0;
    int bus_cnt = 0;

    always #4 clk = ~clk;

    dma_channel i_dma_channel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq)
    );

    function automatic int nb(int s);
        return (s == 0) ? 1 : ((s == 1) ? 2 : 4);
    endfunction

    function automatic logic [31:0] mk_ctrl(bit st, bit req, bit ao, bit si, bit di,
                                            int ss, int ds, bit ie);
        return {22'd0, ie, 2'(ds), 2'(ss), di, si, ao, req, st};
    endfunction

    // bus slave: random ready, little-endian byte memory, item in low bytes
    always @(negedge clk) begin
        logic [31:0] rdv;
        rdv = '0;
        for (int k = 0; k < nb(int'(m_size)); k++) rdv[8*k +: 8] = mem[8'(m_addr) + 8'(k)];
        m_rdata <= rdv;
        m_ready <= ($urandom % 4) != 0;
    end

    always @(posedge clk) begin
        if (!rst && m_valid && m_ready) begin
            bus_cnt++;
            if (m_write)
                for (int k = 0; k < nb(int'(m_size)); k++) mem[8'(m_addr) + 8'(k)] = m_wdata[8*k +: 8];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_read(int idx, output logic [31:0] d);
        cfg_addr = 3'(idx);
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(4, s);
            if (s[0]) begin ok = 1; break; end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            model[i] = mem[i];
        end
    endtask

    task automatic model_run(int src, int dst, int cnt, int ss, int ds, bit si, bit di,
                             output int fs, output int fd);
        int st;
        logic [31:0] w;
        st = (nb(ss) > nb(ds)) ? nb(ss) : nb(ds);
        fs = src; fd = dst;
        for (int n = 0; n < cnt / st; n++) begin
            w = '0;
            for (int k = 0; k < nb(ss); k++) w[8*k +: 8] = model[8'(fs + k)];
            for (int k = 0; k < nb(ds); k++) model[8'(fd + k)] = w[8*k +: 8];
            if (si) fs += nb(ss);
            if (di) fd += nb(ds);
        end
    endtask

    task automatic random_case();
        int ss, ds, st, n, cnt, src, dst, fs, fd, b0, bad;
        bit si, di, ie, ok;
        logic [31:0] r;
        ss = $urandom % 3; ds = $urandom % 3;
        si = 1'($urandom); di = 1'($urandom); ie = 1'($urandom);
        st = (nb(ss) > nb(ds)) ? nb(ss) : nb(ds);
        n = 1 + $urandom % 6;
        cnt = st * n;
        src = ($urandom % 97) & ~(nb(ss) - 1);
        dst = 128 + (($urandom % 97) & ~(nb(ds) - 1));
        fill_mem();
        model_run(src, dst, cnt, ss, ds, si, di, fs, fd);
        reg_write(0, 32'(src));
        reg_write(1, 32'(dst));
        reg_write(2, 32'(cnt));
        b0 = bus_cnt;
        reg_write(3, mk_ctrl(1, 0, 0, si, di, ss, ds, ie));   // R6 single write starts
        wait_done(ok);
        chk("R3 done reached", 32'(ok), 32'd1);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) bad++;
        chk("R12 memory contents", 32'(bad), 32'd0);
        chk("R12 two accesses per item", 32'(bus_cnt - b0), 32'(2 * n));
        reg_read(0, r); chk("R1 final SRC", r, 32'(fs));
        reg_read(1, r); chk("R2 final DST", r, 32'(fd));
        reg_read(2, r); chk("R3 final COUNT", r, 32'd0);
        reg_read(4, r); chk("R3 STAT done not busy", r, 32'd1);
        chk("R10 irq while done", 32'(irq), 32'(ie));
        reg_write(4, 32'd1);
        #1;
        chk("R10 irq after clear", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        bit ok;
        int b0;
        void'($urandom(32'h1d5a));
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; periph_req = 1'b0;
        fill_mem();
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R14 reset state
        for (int i = 0; i < 8; i++) begin
            reg_read(i, r);
            chk("R14 register after reset", r, 32'd0);
        end
        chk("R14 m_valid after reset", 32'(m_valid), 32'd0);
        chk("R14 irq after reset", 32'(irq), 32'd0);

        // R5 peripheral pacing, R13 pointer writes ignored, R7 auto-off
        fill_mem();
        reg_write(0, 32'd8); reg_write(1, 32'd200); reg_write(2, 32'd4);
        b0 = bus_cnt;
        reg_write(3, mk_ctrl(1, 1, 1, 1, 1, 0, 0, 1));
        repeat (20) @(negedge clk);
        chk("R5 no access without request", 32'(bus_cnt - b0), 32'd0);
        reg_read(4, r); chk("R5 armed and busy", r, 32'd2);
        reg_write(0, 32'd40);
        reg_read(0, r); chk("R13 SRC write ignored while busy", r, 32'd8);
        reg_write(2, 32'd64);
        reg_read(2, r); chk("R13 COUNT write ignored while busy", r, 32'd4);
        periph_req = 1'b1;
        wait_done(ok);
        periph_req = 1'b0;
        chk("R5 paced run completes", 32'(ok), 32'd1);
        reg_read(3, r); chk("R7 auto-off cleared request enable", r, mk_ctrl(0, 0, 1, 1, 1, 0, 0, 1));
        chk("R10 irq with enable", 32'(irq), 32'd1);

        // R4 start ignored while done is still set
        reg_write(2, 32'd8);
        b0 = bus_cnt;
        reg_write(3, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 0));
        repeat (10) @(negedge clk);
        reg_read(4, r); chk("R4 STAT stays done, not busy", r, 32'd1);
        chk("R4 no bus access", 32'(bus_cnt - b0), 32'd0);
        reg_read(2, r); chk("R4 COUNT untouched", r, 32'd8);
        reg_write(4, 32'd1);

        // R7 auto-off clear keeps enable; R5 request arms idle channel
        reg_write(0, 32'd0); reg_write(1, 32'd128); reg_write(2, 32'd2);
        periph_req = 1'b1;
        reg_write(3, mk_ctrl(0, 1, 0, 1, 1, 0, 0, 0));
        wait_done(ok);
        periph_req = 1'b0;
        chk("R5 request arms idle channel", 32'(ok), 32'd1);
        reg_read(3, r); chk("R7 enable kept without auto-off", r, mk_ctrl(0, 1, 0, 1, 1, 0, 0, 0));
        reg_read(1, r); chk("R2 DST after request run", r, 32'd130);
        reg_write(3, 32'd0);
        reg_write(4, 32'd1);

        // R11 configuration errors
        b0 = bus_cnt;
        reg_write(2, 32'd0);
        reg_write(3, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 0));
        reg_read(4, r); chk("R11 zero count error", r, 32'd4);
        reg_write(4, 32'd4);
        reg_read(4, r); chk("R11 error cleared", r, 32'd0);
        reg_write(0, 32'd1); reg_write(2, 32'd4);
        reg_write(3, mk_ctrl(1, 0, 0, 1, 1, 2, 0, 0));
        reg_read(4, r); chk("R11 misaligned source error", r, 32'd4);
        reg_write(4, 32'd4);
        reg_write(0, 32'd0); reg_write(2, 32'd6);
        reg_write(3, mk_ctrl(1, 0, 0, 1, 1, 0, 2, 0));
        reg_read(4, r); chk("R11 count not multiple error", r, 32'd4);
        reg_write(4, 32'd4);
        reg_write(2, 32'd4);
        reg_write(3, mk_ctrl(1, 0, 0, 1, 1, 3, 0, 0));
        reg_read(4, r); chk("R11 bad size code error", r, 32'd4);
        reg_write(4, 32'd4);
        chk("R11 no bus access on error", 32'(bus_cnt - b0), 32'd0);

        // R8 abort
        reg_write(0, 32'd0); reg_write(1, 32'd128); reg_write(2, 32'd24);
        reg_write(3, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 0));
        repeat (6) @(negedge clk);
        reg_write(4, 32'd1);
        chk("R8 m_valid low after abort", 32'(m_valid), 32'd0);
        reg_read(4, r); chk("R8 STAT cleared", r, 32'd0);
        reg_read(2, r); chk("R8 COUNT left nonzero", 32'(r != 0 && r < 24), 32'd1);
        b0 = bus_cnt;
        repeat (10) @(negedge clk);
        chk("R8 no further access", 32'(bus_cnt - b0), 32'd0);

        // R9 control write takes effect while active
        reg_write(0, 32'd0); reg_write(1, 32'd128); reg_write(2, 32'd4);
        b0 = bus_cnt;
        reg_write(3, mk_ctrl(1, 1, 0, 1, 1, 1, 1, 0));
        repeat (10) @(negedge clk);
        chk("R9 waiting for request", 32'(bus_cnt - b0), 32'd0);
        reg_write(3, mk_ctrl(0, 0, 0, 1, 1, 1, 1, 0));
        wait_done(ok);
        chk("R9 runs after enable cleared", 32'(ok), 32'd1);
        reg_read(0, r); chk("R1 SRC after halfword run", r, 32'd4);
        reg_write(4, 32'd1);

        // randomized blocks
        for (int t = 0; t < 30; t++) random_case();

        finish_run();
    end

endmodule